// File: doc/BRIEF.md
# Workload-Hint Command Mailbox Responder

This block is the device end of a memory-mapped command mailbox. A host reaches it through a plain 32-bit register port with an address, a write strobe, a read strobe, write data and read data. Two locations matter: a data word and an interface word. The host may first place a payload in the data word. It then writes a command word into the interface word with the busy flag set. The block holds busy for a fixed, parameterised number of clock cycles, carries out the command, and then drops busy. The host sees completion by polling that flag.

Two command codes are recognised. One copies the data word into an internal workload-hint register. The other copies the hint back into the data word so the host can read it. The hint word has three parts: a valid flag, an AC/DC flag and an 8-bit workload index. Indices 0 to 5 stand for none, idle, semi-active, bursty, sustained and battery-life. The block stores the word as written and does not check the index. Read data is registered, so a read strobe in one cycle returns the value held in the register before that clock edge.

Top module: `hint_mailbox`

## Requirements
- R1: After reset, busy is 0, the data word reads 0, the interface word reads 0 and the stored hint is 0.
- R2: If the host writes the interface word (byte offset 0x5818) while idle with bit 31 set, a command starts. From then on the interface word reads back bit 31 = 1 and bits 15:0 = the command code, with all other bits 0.
- R3: Busy stays set for exactly LATENCY cycles after the write that starts the command, and then clears to 0. The command code stays visible in bits 15:0.
- R4: Command code 0x000F copies the whole 32-bit data word (byte offset 0x5810) into the hint register when it completes. In that word, bit 31 is the valid flag, bit 30 is the AC/DC flag and bits 7:0 are the index. The data word itself is left unchanged.
- R5: Command code 0x000E loads the stored hint into the data word when it completes.
- R6: A write to the interface word while busy is set is ignored. It does not change the command code or the completion time.
- R7: A write to the data word while busy is set is dropped. The data word keeps its earlier value.
- R8: Any other command code completes after the same latency. It leaves the hint unchanged and sets the data word to 0.
- R9: A hint whose index is above 5, or an index-0 word with both flags clear, is stored and returned bit for bit.
- R10: A write to the interface word with bit 31 clear starts nothing and changes nothing. Busy and the command code read back as before.
- R11: A write to any other address has no effect, and a read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data appears in bus_rdata after the next edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The cases hardest to reach from the port are the bus accesses that land while a command is still running. The first is a second command word, which must neither restart the timer nor replace the code. The second is a data write, which must not reach the hint. The bench places these writes in the cycles right after the command word. It then polls the interface word on every cycle, so the exact clearing edge is observed. Finally it reads back the hint through a separate read command to show that the dropped data never took effect.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int unsigned BUS_W    = 32;
    localparam int unsigned ADDR_W   = 16;
    localparam int unsigned CMD_W    = 16;
    localparam int unsigned BUSY_BIT = BUS_W - 1;
    localparam int unsigned PAD_W    = BUS_W - CMD_W - 1;

    localparam logic [ADDR_W-1:0] OFS_DATA  = 16'h5810;
    localparam logic [ADDR_W-1:0] OFS_IFACE = 16'h5818;

    localparam logic [CMD_W-1:0] CMD_HINT_SET = 16'h000F;
    localparam logic [CMD_W-1:0] CMD_HINT_GET = 16'h000E;

    typedef enum logic [1:0] {
        RSEL_NONE  = 2'd0,
        RSEL_DATA  = 2'd1,
        RSEL_IFACE = 2'd2
    } rsel_t;

    typedef struct packed {
        logic             busy;
        logic [CMD_W-1:0] cmd;
        logic [BUS_W-1:0] data;
        logic [BUS_W-1:0] hint;
        logic [BUS_W-1:0] rdata;
    } mbx_state_t;
endpackage

// File: rtl/mbx_bus_decode.sv
module mbx_bus_decode
    import mbx_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic              wr_data_hit,
    output logic              wr_iface_hit,
    output rsel_t             rsel
);
    logic is_data;
    logic is_iface;

    always_comb begin
        is_data      = (addr == OFS_DATA);
        is_iface     = (addr == OFS_IFACE);
        wr_data_hit  = wr && is_data;
        wr_iface_hit = wr && is_iface;
        if (is_data) begin
            rsel = RSEL_DATA;
        end else if (is_iface) begin
            rsel = RSEL_IFACE;
        end else begin
            rsel = RSEL_NONE;
        end
    end
endmodule

// File: rtl/mbx_latency_timer.sv
module mbx_latency_timer #(
    parameter int unsigned LATENCY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic busy,
    output logic expire
);
    localparam int unsigned CNT_W = (LATENCY < 2) ? 1 : $clog2(LATENCY);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CNT_LOAD;
        end else if (busy && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
        expire = busy && (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/hint_mailbox.sv
module hint_mailbox
    import mbx_pkg::*;
#(
    parameter int unsigned LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    mbx_state_t st_d;
    mbx_state_t st_q;

    logic  wr_data_hit;
    logic  wr_iface_hit;
    rsel_t rsel;
    logic  start;
    logic  expire;

    mbx_bus_decode u_dec (
        .addr         (bus_addr),
        .wr           (bus_wr),
        .wr_data_hit  (wr_data_hit),
        .wr_iface_hit (wr_iface_hit),
        .rsel         (rsel)
    );

    mbx_latency_timer #(
        .LATENCY (LATENCY)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .busy   (st_q.busy),
        .expire (expire)
    );

    always_comb begin
        st_d  = st_q;
        start = wr_iface_hit && bus_wdata[BUSY_BIT] && !st_q.busy;

        if (wr_data_hit && !st_q.busy) begin
            st_d.data = bus_wdata;
        end

        if (start) begin
            st_d.busy = 1'b1;
            st_d.cmd  = bus_wdata[CMD_W-1:0];
        end

        if (expire) begin
            st_d.busy = 1'b0;
            case (st_q.cmd)
                CMD_HINT_SET: st_d.hint = st_q.data;
                CMD_HINT_GET: st_d.data = st_q.hint;
                default:      st_d.data = '0;
            endcase
        end

        if (bus_rd) begin
            case (rsel)
                RSEL_DATA:  st_d.rdata = st_q.data;
                RSEL_IFACE: st_d.rdata = {st_q.busy, {PAD_W{1'b0}}, st_q.cmd};
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk
    import mbx_pkg::*;
#(
    parameter int unsigned LATENCY = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              busy_q,
    input logic [CMD_W-1:0]  cmd_q,
    input logic [BUS_W-1:0]  data_q,
    input logic [BUS_W-1:0]  hint_q
);
    localparam int unsigned HC_W = $clog2(LATENCY + 1) + 1;

    logic [HC_W-1:0] hi_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q <= '0;
        end else if (busy_q) begin
            hi_cnt_q <= hi_cnt_q + 1'b1;
        end else begin
            hi_cnt_q <= '0;
        end
    end

    // R2
    a_r2_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(bus_wr && (bus_addr == OFS_IFACE) && bus_wdata[BUSY_BIT]));

    // R3
    a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && (hi_cnt_q < HC_W'(LATENCY - 1))) |=> busy_q);

    // R3
    a_r3_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && (hi_cnt_q == HC_W'(LATENCY - 1))) |=> !busy_q);

    // R4
    a_r4_hint_only_on_set: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hint_q) |-> ($fell(busy_q) && (cmd_q == CMD_HINT_SET)));

    // R5
    a_r5_get_returns_hint: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_q) && (cmd_q == CMD_HINT_GET)) |-> (data_q == hint_q));

    // R6
    a_r6_cmd_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> $stable(cmd_q));

    // R7
    a_r7_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> (!busy_q || $stable(data_q)));

    // R8
    a_r8_unknown_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_q) && (cmd_q != CMD_HINT_SET) && (cmd_q != CMD_HINT_GET)) |-> (data_q == '0));

    // R10
    a_r10_clear_bit_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == OFS_IFACE) && !bus_wdata[BUSY_BIT] && !busy_q) |=> !busy_q);
endmodule

bind hint_mailbox mbx_chk #(
    .LATENCY (LATENCY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .busy_q    (st_q.busy),
    .cmd_q     (st_q.cmd),
    .data_q    (st_q.data),
    .hint_q    (st_q.hint)
);

// File: tb/tb_hint_mailbox.sv
module tb_hint_mailbox;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 4;
    localparam logic [15:0] A_DATA  = 16'h5810;
    localparam logic [15:0] A_IFACE = 16'h5818;
    localparam logic [15:0] A_OTHER = 16'h5814;
    localparam logic [31:0] BUSY    = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hint_mailbox #(.LATENCY(LAT)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, input logic [31:0] exp, input string tag);
        item_t it;
        it.exp   = exp;
        it.tag   = tag;
        sb_q.push_back(it);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic issue(input logic [15:0] code);
        bus_write(A_IFACE, BUSY | {16'h0, code});
    endtask

    task automatic settle();
        repeat (LAT + 1) @(negedge clk);
    endtask

    task automatic poll_run(input logic [15:0] code, input int nbusy, input string tag);
        for (int j = 0; j < nbusy; j++) begin
            bus_read(A_IFACE, BUSY | {16'h0, code}, tag);
        end
        bus_read(A_IFACE, {16'h0, code}, tag);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd === 1'b1) begin
                @(negedge clk);
                if (sb_q.size() == 0) begin
                    total++;
                    bad++;
                    $display("FAIL scoreboard: got %h expected no read", bus_rdata);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    total++;
                    if (bus_rdata !== it.exp) begin
                        bad++;
                        $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.exp);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: got hung expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(A_DATA,  32'h0, "R1 data after reset");
        bus_read(A_IFACE, 32'h0, "R1 iface after reset");

        // R10 clear busy bit: nothing starts
        bus_write(A_IFACE, 32'h0000_000E);
        bus_read(A_IFACE, 32'h0, "R10 no start without bit 31");

        // R1 hint is zero after reset
        issue(16'h000E);
        settle();
        bus_read(A_DATA, 32'h0, "R1 hint after reset");

        // R2 R3 R4 store a hint and poll every cycle
        bus_write(A_DATA, 32'hC000_0003);
        issue(16'h000F);
        poll_run(16'h000F, LAT, "R2_R3 busy window for set");
        bus_read(A_DATA, 32'hC000_0003, "R4 data unchanged by set");
        bus_write(A_DATA, 32'h0);
        issue(16'h000E);
        settle();
        bus_read(A_DATA, 32'hC000_0003, "R5 get returns hint");

        // R7 data write while busy is dropped
        bus_write(A_DATA, 32'hC000_0001);
        issue(16'h000F);
        bus_write(A_DATA, 32'hDEAD_BEEF);
        settle();
        bus_read(A_DATA, 32'hC000_0001, "R7 data write dropped");
        bus_write(A_DATA, 32'h0);
        issue(16'h000E);
        settle();
        bus_read(A_DATA, 32'hC000_0001, "R4 set used payload before busy");

        // R6 second command word while busy is ignored
        issue(16'h000E);
        bus_write(A_IFACE, 32'h8000_0033);
        poll_run(16'h000E, LAT - 1, "R6 second command ignored");
        bus_read(A_DATA, 32'hC000_0001, "R6 first command ran");

        // R8 unknown command
        bus_write(A_DATA, 32'h1234_5678);
        issue(16'h0042);
        poll_run(16'h0042, LAT, "R8 unknown command latency");
        bus_read(A_DATA, 32'h0, "R8 unknown zeroes data");
        issue(16'h000E);
        settle();
        bus_read(A_DATA, 32'hC000_0001, "R8 hint unchanged");

        // R9 index above 5 and index 0 stored verbatim
        bus_write(A_DATA, 32'hC000_0009);
        issue(16'h000F);
        settle();
        bus_write(A_DATA, 32'h0);
        issue(16'h000E);
        settle();
        bus_read(A_DATA, 32'hC000_0009, "R9 index 9 kept");
        bus_write(A_DATA, 32'h0000_0000);
        issue(16'h000F);
        settle();
        bus_write(A_DATA, 32'hFFFF_FFFF);
        issue(16'h000E);
        settle();
        bus_read(A_DATA, 32'h0, "R9 index 0 flags clear");

        // R11 other address
        bus_write(A_DATA, 32'h0000_0055);
        bus_write(A_OTHER, 32'hAAAA_5555);
        bus_read(A_OTHER, 32'h0, "R11 other address reads zero");
        bus_read(A_DATA, 32'h0000_0055, "R11 other write no effect on data");
        bus_read(A_IFACE, 32'h0000_000E, "R11 other write no effect on iface");

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
        end
        finish_run();
    end
endmodule